// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Compare and PWM

This block is an 8-bit counter with one compare unit and one waveform output pin. It advances on a timer tick. The tick comes from a free-running 10-bit prescaler, or from an external event input that is synchronized and edge-detected. A clock-select value of zero stops the counter. Four counting modes are available:

- free-running up counting
- clear-on-compare, where the compare value acts as the top of the count
- fast PWM, which counts up and wraps
- phase-correct PWM, which counts up to 0xFF and back down to 0x00

Software uses a small write port to load the control fields, the counter, the compare value and the flag/mask register. The compare value is double buffered. In the two PWM modes a new value waits in a buffer and is copied into the active compare register at the top of the count. In the other modes a write takes effect at once. Overflow and compare-match events set sticky flags. Software clears a flag by writing a one to it. Each flag drives an interrupt request through its own mask bit.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter, the active compare value, the waveform output, both flags and both interrupt requests are zero, and the clock select is zero.
- R2: With clock select 0 (address 0, bits [2:0]) the counter holds its value.
- R3: Clock select values 1, 2, 3, 4 and 5 advance the counter once every 1, 8, 64, 256 and 1024 clock cycles.
- R4: Clock select 7 counts rising edges and clock select 6 counts falling edges of `ext_in`, after a two-stage synchronizer.
- R5: In normal mode (address 0, bits [4:3] = 0) the counter increments and wraps from 0xFF to 0x00. The overflow flag is set in the same cycle as the wrap.
- R6: In clear-on-compare mode (mode 2) the counter returns to 0x00 on the tick after it equals the active compare value, and sets the compare flag. The overflow flag stays clear while the compare value is below 0xFF.
- R7: In modes 0 and 2, a compare match acts on the output according to the action field (address 0, bits [6:5]). Action 1 toggles the output, 2 clears it and 3 sets it. Action 0 forces `wave_o` low.
- R8: In phase-correct mode (mode 1) the counter reverses from 0xFF to 0xFE and from 0x00 to 0x01. The overflow flag is set when a down count reaches 0x00. With action 2, a match while counting down sets the output and a match while counting up clears it. Action 3 does the opposite.
- R9: In fast PWM mode (mode 3) the counter wraps from 0xFF to 0x00 and sets the overflow flag. With action 2 the output is set at the wrap and cleared on a match.
- R10: In modes 1 and 3 a compare write (address 2) changes `cmp_o` only on the tick at 0xFF. In modes 0 and 2 it changes `cmp_o` on the next cycle.
- R11: A write to address 3 clears the overflow flag when bit 0 is one and the compare flag when bit 1 is one. The same write loads the overflow mask from bit 4 and the compare mask from bit 5. Each interrupt request is its flag ANDed with its mask.
- R12: A counter write (address 1) suppresses any compare match on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External event input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 counter, 2 compare, 3 flags/masks |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| cmp_o | output | 8 | Active compare value |
| wave_o | output | 1 | Waveform output pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| ovf_irq | output | 1 | Masked overflow request |
| cmp_irq | output | 1 | Masked compare request |

## Verification
The bench builds the block with its default 8-bit counter and 10-bit prescaler. This keeps a full phase-correct cycle of 510 ticks and a 1024-cycle prescaler tap within a short run. Most scenarios use the undivided tick, so every counter value, turn-around point and buffered compare load falls on a cycle the bench can predict exactly. Every prescaler tap is measured over a ten-tick window. Each external edge polarity is measured across a single held level.

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int W     = 8,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cmp_o,
  output logic         wave_o,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         ovf_irq,
  output logic         cmp_irq
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [1:0] M_NORM = 2'd0, M_PHASE = 2'd1, M_CTC = 2'd2, M_FAST = 2'd3;

  logic [2:0]       sel_q;
  logic [1:0]       mode_q, act_q;
  logic [W-1:0]     cnt_q, ocr_act, ocr_buf, cnt_nxt;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       ext_sh;
  logic             up_q, blk_q, wave_q, wave_nxt, msk_o, msk_c;
  logic             tick, adv, at_top, pwm, hit, ovf_evt;

  wire ctrl_wr = wr_en && wr_addr == 2'd0;
  wire cnt_wr  = wr_en && wr_addr == 2'd1;
  wire ocr_wr  = wr_en && wr_addr == 2'd2;
  wire flg_wr  = wr_en && wr_addr == 2'd3;
  wire ext_rise = ext_sh[1] & ~ext_sh[2];
  wire ext_fall = ~ext_sh[1] & ext_sh[2];

  always_comb begin
    case (sel_q)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = &pre_q;
      3'd6:    tick = ext_fall;
      default: tick = ext_rise;
    endcase
  end

  assign adv     = tick && !cnt_wr;
  assign at_top  = cnt_q == MAX;
  assign pwm     = mode_q == M_PHASE || mode_q == M_FAST;
  assign hit     = adv && !blk_q && cnt_q == ocr_act;
  assign ovf_evt = adv && ((mode_q == M_PHASE) ? (!up_q && cnt_q == ONE) : at_top);

  always_comb begin
    case (mode_q)
      M_PHASE: cnt_nxt = up_q ? (at_top ? MAX - ONE : cnt_q + ONE)
                              : ((cnt_q == '0) ? ONE : cnt_q - ONE);
      M_CTC:   cnt_nxt = (cnt_q == ocr_act) ? '0 : cnt_q + ONE;
      default: cnt_nxt = cnt_q + ONE;
    endcase
  end

  always_comb begin
    wave_nxt = wave_q;
    if (hit) begin
      case (mode_q)
        M_PHASE: if (act_q[1]) wave_nxt = up_q ? act_q[0] : ~act_q[0];
        M_FAST:  if (act_q[1]) wave_nxt = act_q[0];
        default:
          case (act_q)
            2'd1:    wave_nxt = ~wave_q;
            2'd2:    wave_nxt = 1'b0;
            2'd3:    wave_nxt = 1'b1;
            default: wave_nxt = wave_q;
          endcase
      endcase
    end
    if (mode_q == M_FAST && adv && at_top && act_q[1]) wave_nxt = ~act_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ext_sh <= '0;
      sel_q  <= '0;
      mode_q <= M_NORM;
      act_q  <= '0;
      msk_o  <= 1'b0;
      msk_c  <= 1'b0;
    end else begin
      pre_q  <= pre_q + PRE_W'(1);
      ext_sh <= {ext_sh[1:0], ext_in};
      if (ctrl_wr) begin
        sel_q  <= wr_data[2:0];
        mode_q <= wr_data[4:3];
        act_q  <= wr_data[6:5];
      end
      if (flg_wr) begin
        msk_o <= wr_data[4];
        msk_c <= wr_data[5];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      blk_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (cnt_wr)   cnt_q <= wr_data;
      else if (adv) cnt_q <= cnt_nxt;
      if (cnt_wr)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      if (mode_q != M_PHASE) up_q <= 1'b1;
      else if (adv && up_q && at_top) up_q <= 1'b0;
      else if (adv && !up_q && cnt_q == '0) up_q <= 1'b1;
      wave_q <= wave_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_act  <= '0;
      ocr_buf  <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (ocr_wr) ocr_buf <= wr_data;
      if (ocr_wr && !pwm) ocr_act <= wr_data;
      else if (pwm && adv && at_top) ocr_act <= ocr_buf;
      ovf_flag <= (ovf_flag & ~(flg_wr & wr_data[0])) | ovf_evt;
      cmp_flag <= (cmp_flag & ~(flg_wr & wr_data[1])) | hit;
    end
  end

  assign count_o = cnt_q;
  assign cmp_o   = ocr_act;
  assign wave_o  = (act_q != 2'd0) & wave_q;
  assign ovf_irq = ovf_flag & msk_o;
  assign cmp_irq = cmp_flag & msk_c;

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));
  assert_normal_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NORM && adv && at_top) |=> (ovf_flag && cnt_q == '0));
  assert_ctc_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CTC && adv && cnt_q == ocr_act) |=> (cnt_q == '0));
  assert_phase_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PHASE && !ctrl_wr && adv && up_q && at_top) |=> (cnt_q == MAX - ONE && !up_q));
  assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !(adv && at_top)) |=> $stable(ocr_act));
endmodule

// File: tb/tb_pwm_timer8.sv
module tb_pwm_timer8;
  logic clk = 0, rst_n = 0, ext_in = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count_o, cmp_o;
  logic wave_o, ovf_flag, cmp_flag, ovf_irq, cmp_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timer8 dut (.clk, .rst_n, .ext_in, .wr_en, .wr_addr, .wr_data, .count_o, .cmp_o,
                  .wave_o, .ovf_flag, .cmp_flag, .ovf_irq, .cmp_irq);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ctrl(logic [1:0] act, logic [1:0] mode, logic [2:0] sel);
    wr(2'd0, {1'b0, act, mode, sel});
  endtask

  task automatic flags(bit mc, bit mo, bit cc, bit co);
    wr(2'd3, {2'b0, mc, mo, 2'b0, cc, co});
  endtask

  task automatic t_reset;
    chk("R1", "count", count_o, 0);
    chk("R1", "cmp", cmp_o, 0);
    chk("R1", "wave", wave_o, 0);
    chk("R1", "flags", {ovf_flag, cmp_flag, ovf_irq, cmp_irq}, 0);
  endtask

  task automatic t_stopped;
    wr(2'd1, 8'h37);
    step(20);
    chk("R2", "held count", count_o, 8'h37);
  endtask

  task automatic t_normal;
    ctrl(2'd0, 2'd0, 3'd0);
    wr(2'd1, 8'hFD);
    flags(0, 0, 1, 1);
    ctrl(2'd0, 2'd0, 3'd1);
    chk("R5", "start", count_o, 8'hFD);
    step(2);
    chk("R5", "at FF", count_o, 8'hFF);
    chk("R5", "no ovf yet", ovf_flag, 0);
    step(1);
    chk("R5", "wrapped", count_o, 8'h00);
    chk("R5", "ovf set", ovf_flag, 1);
    chk("R11", "masked irq", ovf_irq, 0);
    flags(0, 1, 0, 0);
    chk("R11", "unmasked irq", ovf_irq, 1);
    flags(0, 1, 0, 1);
    chk("R11", "w1c flag", ovf_flag, 0);
    chk("R11", "irq drops", ovf_irq, 0);
  endtask

  task automatic t_prescale(logic [2:0] sel, int div);
    ctrl(2'd0, 2'd0, 3'd0);
    wr(2'd1, 8'h00);
    ctrl(2'd0, 2'd0, sel);
    step(10 * div);
    chk("R3", $sformatf("ticks div %0d", div), count_o, 10);
  endtask

  task automatic t_external;
    ctrl(2'd0, 2'd0, 3'd0);
    wr(2'd1, 8'h00);
    ctrl(2'd0, 2'd0, 3'd7);
    repeat (5) begin ext_in = 1; step(3); ext_in = 0; step(3); end
    step(6);
    chk("R4", "rising edges", count_o, 5);
    ctrl(2'd0, 2'd0, 3'd6);
    wr(2'd1, 8'h00);
    ext_in = 1; step(8);
    chk("R4", "rise ignored", count_o, 0);
    ext_in = 0; step(8);
    chk("R4", "falling edge", count_o, 1);
  endtask

  task automatic t_ctc(logic [1:0] act);
    logic w0;
    ctrl(act, 2'd2, 3'd0);
    wr(2'd2, 8'h05);
    chk("R10", "immediate load", cmp_o, 8'h05);
    wr(2'd1, 8'h00);
    flags(0, 0, 1, 1);
    w0 = wave_o;
    ctrl(act, 2'd2, 3'd1);
    step(5);
    chk("R6", "count at top", count_o, 5);
    chk("R6", "no match yet", cmp_flag, 0);
    step(1);
    chk("R6", "reloaded", count_o, 0);
    chk("R6", "match flag", cmp_flag, 1);
    chk("R7", $sformatf("action %0d", act), wave_o, act == 1 ? !w0 : (act == 3));
    if (act == 1) begin
      step(6);
      chk("R7", "toggle back", wave_o, w0);
      step(20);
      chk("R6", "no overflow", ovf_flag, 0);
    end
  endtask

  task automatic t_disconnect;
    ctrl(2'd0, 2'd2, 3'd1);
    step(12);
    chk("R7", "action 0 low", wave_o, 0);
  endtask

  task automatic t_block;
    ctrl(2'd0, 2'd0, 3'd0);
    wr(2'd2, 8'h10);
    wr(2'd1, 8'h10);
    flags(0, 0, 1, 1);
    ctrl(2'd0, 2'd0, 3'd1);
    step(20);
    chk("R12", "match suppressed", cmp_flag, 0);
    chk("R12", "count ran", count_o, 8'h24);
    ctrl(2'd0, 2'd0, 3'd0);
    wr(2'd1, 8'h0F);
    ctrl(2'd0, 2'd0, 3'd1);
    step(2);
    chk("R12", "later match counts", cmp_flag, 1);
  endtask

  task automatic t_phase;
    ctrl(2'd2, 2'd1, 3'd0);
    wr(2'd2, 8'h40);
    chk("R10", "buffered", cmp_o, 8'h10);
    wr(2'd1, 8'hF0);
    flags(0, 0, 1, 1);
    ctrl(2'd2, 2'd1, 3'd1);
    step(15);
    chk("R8", "at FF", count_o, 8'hFF);
    chk("R10", "still old", cmp_o, 8'h10);
    step(1);
    chk("R8", "turned down", count_o, 8'hFE);
    chk("R10", "loaded at top", cmp_o, 8'h40);
    step(191);
    chk("R8", "down count", count_o, 8'h3F);
    chk("R8", "set on down match", wave_o, 1);
    chk("R8", "match flag", cmp_flag, 1);
    step(62);
    chk("R8", "no ovf before bottom", ovf_flag, 0);
    step(1);
    chk("R8", "bottom", count_o, 0);
    chk("R8", "ovf at bottom", ovf_flag, 1);
    step(1);
    chk("R8", "turned up", count_o, 1);
    step(64);
    chk("R8", "clear on up match", wave_o, 0);
    chk("R8", "up count", count_o, 8'h41);
  endtask

  task automatic t_fast;
    ctrl(2'd2, 2'd3, 3'd0);
    wr(2'd2, 8'h80);
    chk("R10", "fast buffered", cmp_o, 8'h40);
    wr(2'd1, 8'hFE);
    flags(0, 0, 1, 1);
    ctrl(2'd2, 2'd3, 3'd1);
    step(2);
    chk("R9", "wrap", count_o, 0);
    chk("R9", "ovf", ovf_flag, 1);
    chk("R9", "set at bottom", wave_o, 1);
    chk("R10", "fast loaded", cmp_o, 8'h80);
    step(128);
    chk("R9", "high before match", wave_o, 1);
    step(1);
    chk("R9", "cleared on match", wave_o, 0);
    chk("R9", "cmp flag", cmp_flag, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_stopped();
    t_normal();
    t_prescale(3'd2, 8);
    t_prescale(3'd3, 64);
    t_prescale(3'd4, 256);
    t_prescale(3'd5, 1024);
    t_external();
    t_ctc(2'd1);
    t_ctc(2'd3);
    t_ctc(2'd2);
    t_disconnect();
    t_block();
    t_phase();
    t_fast();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule